// File: doc/BRIEF.md
# Modem Handshake Status Register

This block is a 32-bit memory-mapped status word for the four active-low handshake inputs of a serial port: carrier detect, ring indicator, data set ready and clear to send. Each raw pin passes through a two-stage synchronizer. The word then reports the current level of each line, with a 1 meaning the pin is low. It also holds a sticky change flag for every line and one software-writable flow-control enable bit. An interrupt output stays high while any change flag is set.

Software reaches the word through a simple register bus. The bus has an address, a write enable with write data, and a read enable with read data returned in the same cycle. A build-time parameter selects how the change flags are cleared. In the default mode, a read of the word clears all four flags. In the other mode, software writes a 1 to a flag's bit position to clear that flag, and reads have no side effect. A pin edge that arrives in the same cycle as a clear always wins, so no event is lost.

Top module: `modem_status_reg`

## Requirements
- R1: After reset the word reads 0x0000_0000 and the interrupt is low. Bits 31 to 9 always read 0, whatever is written to them.
- R2: Bit 8 is a plain read/write flow-control enable. A write to the register address loads it from write data bit 8, and a read returns the stored value.
- R3: Bits 7, 6, 5 and 4 show the synchronized levels of carrier detect, ring indicator, data set ready and clear to send, in that order. Each bit reads 1 when its pin is low. A pin change shows in the read word two clock edges after the pin changes.
- R4: Any level change of the carrier detect pin sets bit 3. Any level change of the data set ready pin sets bit 1, and any level change of the clear to send pin sets bit 0. The flag is set on the third clock edge after the pin changes, and it stays set until it is cleared.
- R5: Bit 2 is set only when the ring indicator pin goes from high to low. A low-to-high change leaves bit 2 at 0.
- R6: With CLEAR_ON_READ=1 (the default), a read of the register address returns the flags as they were before the read, then clears all four flags on that clock edge. Writes have no effect on bits 3 to 0.
- R7: With CLEAR_ON_READ=0, a write clears each flag whose write data bit is 1. A 0 in write data leaves that flag unchanged, and reads do not change the flags.
- R8: If a line's change event and a clear of its flag fall on the same clock edge, the flag ends up set.
- R9: The interrupt output is high exactly while at least one of bits 3 to 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 32 | Read data, same cycle as the read strobe; 0 when not reading this address |
| carrier_n_i | input | 1 | Raw carrier detect pin, active low |
| ring_n_i | input | 1 | Raw ring indicator pin, active low |
| set_ready_n_i | input | 1 | Raw data set ready pin, active low |
| clear_send_n_i | input | 1 | Raw clear to send pin, active low |
| irq_o | output | 1 | High while any change flag is set |

## Verification
A pin change reaches the level bits after two rising edges and the change flag after three. The bench changes each pin at a falling edge and counts falling edges before it samples. It reads once when the level is visible but the flag is not yet set. That read spans the edge on which the flag sets, so it also covers the case of an event arriving together with a clear. Each read is sampled shortly after the falling edge on which the strobe is raised, which is before the clear takes effect. Each write acts on the next rising edge, so the bench checks its result in the read that follows.

// File: rtl/modem_status_pkg.sv
package modem_status_pkg;

    localparam int unsigned NUM_LINES = 4;

    // line index inside every 4-bit line vector
    localparam int unsigned LN_CLEAR_SEND = 0;
    localparam int unsigned LN_SET_READY  = 1;
    localparam int unsigned LN_RING       = 2;
    localparam int unsigned LN_CARRIER    = 3;

    // word layout
    localparam int unsigned FLAG_LSB  = 0;
    localparam int unsigned LEVEL_LSB = FLAG_LSB + NUM_LINES;
    localparam int unsigned FC_BIT    = LEVEL_LSB + NUM_LINES;
    localparam int unsigned USED_BITS = FC_BIT + 1;

    // lines whose flag sets only on a pin falling edge
    localparam logic [NUM_LINES-1:0] FALL_ONLY_MASK = NUM_LINES'(1) << LN_RING;

    typedef struct packed {
        logic                 fc_en;
        logic [NUM_LINES-1:0] flags;
    } stat_state_t;

endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= RESET_VAL;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/modem_delta.sv
module modem_delta #(
    parameter int unsigned WIDTH = 4,
    parameter logic [WIDTH-1:0] FALL_ONLY = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_lvl,
    output logic [WIDTH-1:0] active,
    output logic [WIDTH-1:0] event_o
);

    logic [WIDTH-1:0] prev_d;
    logic [WIDTH-1:0] prev_q;

    always_comb begin
        prev_d = pin_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign active = ~pin_lvl;

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        if (FALL_ONLY[i]) begin : g_fall
            assign event_o[i] = prev_q[i] & ~pin_lvl[i];
        end else begin : g_any
            assign event_o[i] = prev_q[i] ^ pin_lvl[i];
        end
    end

endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
    import modem_status_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0C,
    parameter bit CLEAR_ON_READ = 1'b1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [31:0]       bus_wr_data,
    input  logic              bus_rd_en,
    output logic [31:0]       bus_rd_data,
    input  logic              carrier_n_i,
    input  logic              ring_n_i,
    input  logic              set_ready_n_i,
    input  logic              clear_send_n_i,
    output logic              irq_o
);

    localparam int unsigned PAD_W = 32 - USED_BITS;

    logic [NUM_LINES-1:0] raw_pins;
    logic [NUM_LINES-1:0] sync_pins;
    logic [NUM_LINES-1:0] line_active;
    logic [NUM_LINES-1:0] line_event;
    logic [NUM_LINES-1:0] clr_mask;
    logic                 rd_hit;
    logic                 wr_hit;
    stat_state_t          st_d;
    stat_state_t          st_q;

    always_comb begin
        raw_pins                = '1;
        raw_pins[LN_CARRIER]    = carrier_n_i;
        raw_pins[LN_RING]       = ring_n_i;
        raw_pins[LN_SET_READY]  = set_ready_n_i;
        raw_pins[LN_CLEAR_SEND] = clear_send_n_i;
    end

    modem_sync #(
        .WIDTH     (NUM_LINES),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ('1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_pins),
        .dout  (sync_pins)
    );

    modem_delta #(
        .WIDTH     (NUM_LINES),
        .FALL_ONLY (FALL_ONLY_MASK)
    ) u_delta (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_lvl (sync_pins),
        .active  (line_active),
        .event_o (line_event)
    );

    always_comb begin
        rd_hit = bus_rd_en && (bus_addr == REG_ADDR);
        wr_hit = bus_wr_en && (bus_addr == REG_ADDR);

        if (CLEAR_ON_READ) begin
            clr_mask = {NUM_LINES{rd_hit}};
        end else if (wr_hit) begin
            clr_mask = bus_wr_data[FLAG_LSB +: NUM_LINES];
        end else begin
            clr_mask = '0;
        end

        st_d = st_q;
        // a new event outranks a clear on the same edge
        st_d.flags = (st_q.flags & ~clr_mask) | line_event;
        if (wr_hit) begin
            st_d.fc_en = bus_wr_data[FC_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rd_data = rd_hit ? {{PAD_W{1'b0}}, st_q.fc_en, line_active, st_q.flags} : 32'h0;
    assign irq_o       = |st_q.flags;

endmodule

module modem_status_chk #(
    parameter bit CLEAR_ON_READ = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_hit,
    input logic        wr_hit,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic [3:0]  line_event,
    input logic [3:0]  flags,
    input logic        fc_en,
    input logic        irq
);

    // R1
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31:9] == 23'h0);

    // R2
    fc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (fc_en == $past(wr_data[8])));

    // R4
    flag_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_event != 4'h0) |=> ((flags & $past(line_event)) == $past(line_event)));

    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CLEAR_ON_READ && rd_hit && line_event == 4'h0) |=> (flags == 4'h0));

    // R7
    w1c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!CLEAR_ON_READ && !wr_hit) |=> ((flags & $past(flags)) == $past(flags)));

    // R9
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 4'h0 && line_event == 4'h0) |=> !irq);

endmodule

bind modem_status_reg modem_status_chk #(
    .CLEAR_ON_READ (CLEAR_ON_READ)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_hit     (rd_hit),
    .wr_hit     (wr_hit),
    .wr_data    (bus_wr_data),
    .rd_data    (bus_rd_data),
    .line_event (line_event),
    .flags      (st_q.flags),
    .fc_en      (st_q.fc_en),
    .irq        (irq_o)
);

// File: tb/modem_status_reg_bench.sv
module modem_status_reg_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] RADDR = 8'h0C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic [7:0]  addr_a = '0, addr_b = '0;
    logic        wen_a = 0, wen_b = 0, ren_a = 0, ren_b = 0;
    logic [31:0] wdat_a = '0, wdat_b = '0;
    logic [31:0] rdat_a, rdat_b;
    logic        irq_a, irq_b;
    logic        car_a = 1, ring_a = 1, dsr_a = 1, cts_a = 1;
    logic        cts_b = 1;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modem_status_reg u_modem_status_reg (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr_a), .bus_wr_en(wen_a),
        .bus_wr_data(wdat_a), .bus_rd_en(ren_a), .bus_rd_data(rdat_a),
        .carrier_n_i(car_a), .ring_n_i(ring_a), .set_ready_n_i(dsr_a),
        .clear_send_n_i(cts_a), .irq_o(irq_a)
    );

    modem_status_reg #(.CLEAR_ON_READ(1'b0)) u_modem_status_reg_w1c (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr_b), .bus_wr_en(wen_b),
        .bus_wr_data(wdat_b), .bus_rd_en(ren_b), .bus_rd_data(rdat_b),
        .carrier_n_i(1'b1), .ring_n_i(1'b1), .set_ready_n_i(1'b1),
        .clear_send_n_i(cts_b), .irq_o(irq_b)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_a(output logic [31:0] v);
        addr_a = RADDR; ren_a = 1;
        #1 v = rdat_a;
        @(negedge clk);
        ren_a = 0;
    endtask

    task automatic rd_b(output logic [31:0] v);
        addr_b = RADDR; ren_b = 1;
        #1 v = rdat_b;
        @(negedge clk);
        ren_b = 0;
    endtask

    task automatic wr_a(input logic [31:0] d);
        addr_a = RADDR; wdat_a = d; wen_a = 1;
        @(negedge clk);
        wen_a = 0;
    endtask

    task automatic wr_b(input logic [31:0] d);
        addr_b = RADDR; wdat_b = d; wen_b = 1;
        @(negedge clk);
        wen_b = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq after reset", {31'h0, irq_a}, 32'h0);
        rd_a(v);
        check("R1 word after reset", v, 32'h0);
    endtask

    task automatic t_carrier();
        logic [31:0] v;
        car_a = 0;
        idle(2);
        rd_a(v);
        check("R3 level after two edges, flag not yet", v, 32'h80);
        check("R9 irq with flag set", {31'h0, irq_a}, 32'h1);
        rd_a(v);
        check("R8 flag kept over same-edge read", v, 32'h88);
        rd_a(v);
        check("R6 read cleared flags", v, 32'h80);
        check("R9 irq low after clear", {31'h0, irq_a}, 32'h0);
        car_a = 1;
        idle(4);
        rd_a(v);
        check("R4 carrier rising sets flag", v, 32'h08);
        rd_a(v);
        check("R6 second read clean", v, 32'h0);
    endtask

    task automatic t_ring();
        logic [31:0] v;
        ring_a = 0;
        idle(4);
        rd_a(v);
        check("R5 ring falling sets flag", v, 32'h44);
        ring_a = 1;
        idle(4);
        rd_a(v);
        check("R5 ring rising no flag", v, 32'h0);
    endtask

    task automatic t_dsr_cts();
        logic [31:0] v;
        dsr_a = 0; cts_a = 0;
        idle(4);
        rd_a(v);
        check("R4 dsr/cts falling", v, 32'h33);
        dsr_a = 1; cts_a = 1;
        idle(4);
        rd_a(v);
        check("R4 dsr/cts rising", v, 32'h03);
        rd_a(v);
        check("R6 cleared", v, 32'h0);
    endtask

    task automatic t_fc();
        logic [31:0] v;
        cts_a = 0;
        idle(4);
        wr_a(32'hFFFF_FFFF);
        rd_a(v);
        check("R2 R1 R6 fc set, upper zero, write kept flag", v, 32'h111);
        wr_a(32'h0);
        rd_a(v);
        check("R2 fc cleared", v, 32'h010);
        cts_a = 1;
        idle(4);
        rd_a(v);
        check("R4 cts rising", v, 32'h001);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        cts_b = 0;
        idle(4);
        rd_b(v);
        check("R7 flag set", v, 32'h11);
        rd_b(v);
        check("R7 read has no effect", v, 32'h11);
        wr_b(32'h0000_000E);
        rd_b(v);
        check("R7 zero bit keeps flag", v, 32'h11);
        wr_b(32'h0000_0001);
        rd_b(v);
        check("R7 write one clears", v, 32'h10);
        check("R9 irq low after w1c", {31'h0, irq_b}, 32'h0);
        cts_b = 1;
        idle(2);
        wr_b(32'h0000_0001);
        rd_b(v);
        check("R8 event wins over same-edge w1c", v, 32'h01);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        t_reset();
        t_carrier();
        t_ring();
        t_dsr_cts();
        t_fc();
        t_w1c();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule